// File: doc/BRIEF.md
# Two-Wire Serial LCD Nibble Writer

This block writes one 4-bit nibble, together with a register-select bit, into a character display that is wired in 4-bit mode behind an external 8-stage serial-in, parallel-out shift register. Only two wires leave the block: a serial data line and a shift clock. The display enable has no wire of its own. Outside the chip, a diode-AND combines the seventh register stage with the data line. The block shifts a marker one into that stage and then holds the data line high with no clock edge, and that forms the enable pulse.

A write request is accepted only while the block is idle. The block then shifts out a run of zeros that clears the enable stage, then the marker, the select bit, the four nibble bits from most to least significant, and one zero that moves every field onto its display pin. It then drives the enable strobe, waits a settle time for the display, and raises a one-cycle done pulse. Clock phase widths, strobe width and settle time are counted in system clock cycles. At 100 MHz the strobe width must be at least 45 cycles, for at least 450 ns. Splitting bytes into nibbles and display initialization are handled above this block.

Top module: `lcd2w_writer`

## Requirements
- R1: After reset, and in every cycle in which busy is low, ser_data and ser_clk are low. done is low after reset, and an asynchronous reset in the middle of a write returns all outputs to low at once.
- R2: The data values sampled at the rising edges of ser_clk during one write are, in order: the leading zeros, a single one (the marker), req_rs, req_nibble bit 3, bit 2, bit 1, bit 0, and a final zero. No other rising edge occurs in the write.
- R3: The number of leading zeros is LEAD_FIRST (default 7) for the first write after reset and LEAD_NEXT (default 6) for every later write. A write therefore has LEAD_FIRST+7 or LEAD_NEXT+7 rising ser_clk edges.
- R4: A request is accepted at the rising system clock edge where req_valid is high and busy is low. In the next cycle busy is high and ser_data and ser_clk are low. Every low phase of ser_clk lasts CLK_LO_CYC cycles and every high phase lasts CLK_HI_CYC cycles.
- R5: ser_data changes only in cycles where ser_clk is low. It keeps the same value for every cycle in which ser_clk is high.
- R6: After the last falling edge of ser_clk in a write, ser_data is high for exactly STROBE_CYC cycles with ser_clk low, and then returns low.
- R7: Model the external register as 8 stages that take ser_data into stage 0 at each rising ser_clk edge. The product of stage 6 and ser_data is then high exactly once per write, for STROBE_CYC cycles. While it is high, stage 6 is 1, stage 5 holds req_rs, and stages 4 down to 1 hold req_nibble bits 3 down to 0.
- R8: done is a one-cycle pulse that rises SETTLE_CYC cycles after ser_data falls at the end of the strobe, or in the same cycle when SETTLE_CYC is 0. busy falls in the cycle in which done is high, and the two are never high together.
- R9: A request presented while busy is high is dropped. The write in progress continues unchanged, and the dropped request is never carried out later.
- R10: A request that is present in the cycle in which done is high is accepted at the next clock edge, so busy is high again one cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request, taken when busy is low |
| req_rs | input | 1 | Register-select value for this nibble |
| req_nibble | input | 4 | Nibble destined for display data pins 7 down to 4 |
| busy | output | 1 | High from the cycle after acceptance until done |
| done | output | 1 | One-cycle pulse when the write and the settle time are complete |
| ser_data | output | 1 | Serial data line, also forms the enable strobe |
| ser_clk | output | 1 | Shift clock for the external register |

## Verification
The end of one write (the done pulse with busy falling) and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising req_valid as soon as it sees done. It judges the result by busy being high in the very next cycle and by the second write arriving complete, with six leading zeros and correct register fields at the enable pulse. A second overlap, a request arriving while a write is shifting, is judged by comparing the finished stream with the first request alone and by the absence of any later clock edge.

// File: rtl/lcd2w_pkg.sv
package lcd2w_pkg;

   // bits carried by one nibble write after the leading zeros:
   // marker, select, four data bits, trailing align zero
   localparam int unsigned LCD2W_NIB_W     = 4;
   localparam int unsigned LCD2W_TAIL_BITS = LCD2W_NIB_W + 3;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_LOW    = 3'd1,
      PH_HIGH   = 3'd2,
      PH_STROBE = 3'd3,
      PH_SETTLE = 3'd4
   } lcd2w_phase_e;

   function automatic int unsigned lcd2w_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lcd2w_timer.sv
// Down counter shared by every timed phase. A phase that loads N-1
// lasts N cycles; expired is high in the last one.
module lcd2w_timer #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/lcd2w_framer.sv
// Holds the bits still to be sent after the one on the line. The bit
// on the line at acceptance is always a leading zero, so the register
// keeps only what follows it.
module lcd2w_framer
   import lcd2w_pkg::*;
#(
   parameter int unsigned LEAD_FIRST = 7,
   parameter int unsigned LEAD_NEXT  = 6,
   parameter int unsigned FRAME_W    = LEAD_FIRST + LCD2W_TAIL_BITS - 1,
   parameter int unsigned IDX_W      = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic                   advance,
   input  logic                   rs,
   input  logic [LCD2W_NIB_W-1:0] nibble,
   output logic                   next_bit,
   output logic                   last
);

   logic [LCD2W_TAIL_BITS-1:0] tail_w;
   logic [IDX_W-1:0]           lead_sel;
   logic [FRAME_W-1:0]         frame_q;
   logic [IDX_W-1:0]           remain_q;

   // tail in send order, earliest bit at index 0
   assign tail_w[0] = 1'b1;
   assign tail_w[1] = rs;
   for (genvar g = 0; g < LCD2W_NIB_W; g++) begin : g_nib
      assign tail_w[2 + g] = nibble[LCD2W_NIB_W - 1 - g];
   end
   assign tail_w[LCD2W_TAIL_BITS-1] = 1'b0;

   // the zero run after reset may be longer than between writes
   if (LEAD_FIRST == LEAD_NEXT) begin : g_lead_fixed
      assign lead_sel = IDX_W'(LEAD_FIRST);
   end else begin : g_lead_two
      logic first_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            first_q <= 1'b1;
         end else if (load) begin
            first_q <= 1'b0;
         end
      end
      assign lead_sel = first_q ? IDX_W'(LEAD_FIRST) : IDX_W'(LEAD_NEXT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q  <= '0;
         remain_q <= '0;
      end else if (load) begin
         frame_q  <= FRAME_W'(tail_w) << (lead_sel - IDX_W'(1));
         remain_q <= lead_sel + IDX_W'(LCD2W_TAIL_BITS);
      end else if (advance) begin
         frame_q <= frame_q >> 1;
         if (remain_q != '0) begin
            remain_q <= remain_q - IDX_W'(1);
         end
      end
   end

   assign next_bit = frame_q[0];
   assign last     = (remain_q == IDX_W'(1));

endmodule

// File: rtl/lcd2w_seq.sv
// Phase sequencer: low/high shift clock phases, enable strobe, settle.
// All outputs are registered, so the pins never glitch.
module lcd2w_seq
   import lcd2w_pkg::*;
#(
   parameter int unsigned CLK_HI_CYC = 4,
   parameter int unsigned CLK_LO_CYC = 4,
   parameter int unsigned STROBE_CYC = 46,
   parameter int unsigned SETTLE_CYC = 10,
   parameter int unsigned CNT_W      = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             tm_expired,
   input  logic             fr_last,
   input  logic             fr_next_bit,
   output logic             tm_load,
   output logic [CNT_W-1:0] tm_val,
   output logic             fr_load,
   output logic             fr_advance,
   output logic             ser_data,
   output logic             ser_clk,
   output logic             busy,
   output logic             done
);

   localparam bit HAS_SETTLE = (SETTLE_CYC != 0);
   localparam int unsigned SETTLE_LD = HAS_SETTLE ? SETTLE_CYC - 1 : 0;
   localparam logic [CNT_W-1:0] LD_LO  = CNT_W'(CLK_LO_CYC - 1);
   localparam logic [CNT_W-1:0] LD_HI  = CNT_W'(CLK_HI_CYC - 1);
   localparam logic [CNT_W-1:0] LD_STB = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] LD_SET = CNT_W'(SETTLE_LD);

   lcd2w_phase_e ph_q, ph_d;
   logic         data_d, sclk_d, busy_d, done_d;

   always_comb begin
      ph_d       = ph_q;
      data_d     = ser_data;
      sclk_d     = ser_clk;
      busy_d     = busy;
      done_d     = 1'b0;
      tm_load    = 1'b0;
      tm_val     = '0;
      fr_load    = 1'b0;
      fr_advance = 1'b0;
      unique case (ph_q)
         PH_IDLE: begin
            if (req_valid) begin
               ph_d    = PH_LOW;
               busy_d  = 1'b1;
               data_d  = 1'b0;
               sclk_d  = 1'b0;
               fr_load = 1'b1;
               tm_load = 1'b1;
               tm_val  = LD_LO;
            end
         end
         PH_LOW: begin
            if (tm_expired) begin
               ph_d    = PH_HIGH;
               sclk_d  = 1'b1;
               tm_load = 1'b1;
               tm_val  = LD_HI;
            end
         end
         PH_HIGH: begin
            if (tm_expired) begin
               sclk_d     = 1'b0;
               fr_advance = 1'b1;
               tm_load    = 1'b1;
               if (fr_last) begin
                  ph_d   = PH_STROBE;
                  data_d = 1'b1;
                  tm_val = LD_STB;
               end else begin
                  ph_d   = PH_LOW;
                  data_d = fr_next_bit;
                  tm_val = LD_LO;
               end
            end
         end
         PH_STROBE: begin
            if (tm_expired) begin
               data_d = 1'b0;
               if (HAS_SETTLE) begin
                  ph_d    = PH_SETTLE;
                  tm_load = 1'b1;
                  tm_val  = LD_SET;
               end else begin
                  ph_d   = PH_IDLE;
                  busy_d = 1'b0;
                  done_d = 1'b1;
               end
            end
         end
         PH_SETTLE: begin
            if (tm_expired) begin
               ph_d   = PH_IDLE;
               busy_d = 1'b0;
               done_d = 1'b1;
            end
         end
         default: begin
            ph_d   = PH_IDLE;
            busy_d = 1'b0;
            data_d = 1'b0;
            sclk_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         ser_data <= 1'b0;
         ser_clk  <= 1'b0;
         busy     <= 1'b0;
         done     <= 1'b0;
      end else begin
         ph_q     <= ph_d;
         ser_data <= data_d;
         ser_clk  <= sclk_d;
         busy     <= busy_d;
         done     <= done_d;
      end
   end

endmodule

// File: rtl/lcd2w_writer.sv
module lcd2w_writer
   import lcd2w_pkg::*;
#(
   parameter int unsigned CLK_HI_CYC = 4,
   parameter int unsigned CLK_LO_CYC = 4,
   parameter int unsigned STROBE_CYC = 46,
   parameter int unsigned SETTLE_CYC = 10,
   parameter int unsigned LEAD_FIRST = 7,
   parameter int unsigned LEAD_NEXT  = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_rs,
   input  logic [LCD2W_NIB_W-1:0] req_nibble,
   output logic                   busy,
   output logic                   done,
   output logic                   ser_data,
   output logic                   ser_clk
);

   localparam int unsigned MAX_CYC = lcd2w_max(lcd2w_max(CLK_HI_CYC, CLK_LO_CYC),
                                               lcd2w_max(STROBE_CYC, SETTLE_CYC));
   localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
   localparam int unsigned FRAME_W = LEAD_FIRST + LCD2W_TAIL_BITS - 1;
   localparam int unsigned IDX_W   = $clog2(LEAD_FIRST + LCD2W_TAIL_BITS + 1);

   // elaboration-time parameter checks
   if (CLK_HI_CYC < 1) begin : g_bad_hi
      $error("lcd2w_writer: CLK_HI_CYC must be at least 1");
   end
   if (CLK_LO_CYC < 1) begin : g_bad_lo
      $error("lcd2w_writer: CLK_LO_CYC must be at least 1");
   end
   if (STROBE_CYC < 1) begin : g_bad_stb
      $error("lcd2w_writer: STROBE_CYC must be at least 1");
   end
   if (LEAD_FIRST < 7) begin : g_bad_lead_first
      $error("lcd2w_writer: LEAD_FIRST below 7 cannot clear an unknown register");
   end
   if (LEAD_NEXT < 6) begin : g_bad_lead_next
      $error("lcd2w_writer: LEAD_NEXT below 6 leaves the enable stage set");
   end
   if (LEAD_NEXT > LEAD_FIRST) begin : g_bad_lead_order
      $error("lcd2w_writer: LEAD_NEXT may not exceed LEAD_FIRST");
   end

   logic             tm_load, tm_expired;
   logic [CNT_W-1:0] tm_val;
   logic             fr_load, fr_advance, fr_next_bit, fr_last;

   lcd2w_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .expired  (tm_expired)
   );

   lcd2w_framer #(
      .LEAD_FIRST (LEAD_FIRST),
      .LEAD_NEXT  (LEAD_NEXT),
      .FRAME_W    (FRAME_W),
      .IDX_W      (IDX_W)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fr_load),
      .advance  (fr_advance),
      .rs       (req_rs),
      .nibble   (req_nibble),
      .next_bit (fr_next_bit),
      .last     (fr_last)
   );

   lcd2w_seq #(
      .CLK_HI_CYC (CLK_HI_CYC),
      .CLK_LO_CYC (CLK_LO_CYC),
      .STROBE_CYC (STROBE_CYC),
      .SETTLE_CYC (SETTLE_CYC),
      .CNT_W      (CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .tm_expired  (tm_expired),
      .fr_last     (fr_last),
      .fr_next_bit (fr_next_bit),
      .tm_load     (tm_load),
      .tm_val      (tm_val),
      .fr_load     (fr_load),
      .fr_advance  (fr_advance),
      .ser_data    (ser_data),
      .ser_clk     (ser_clk),
      .busy        (busy),
      .done        (done)
   );

endmodule

// File: rtl/lcd2w_writer_chk.sv
module lcd2w_writer_chk #(
   parameter int unsigned STROBE_CYC = 46,
   parameter int unsigned LEAD_FIRST = 7,
   parameter int unsigned LEAD_NEXT  = 6
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic done,
   input logic ser_data,
   input logic ser_clk
);

   logic        first_q;
   logic        sclk_prev_q;
   logic [15:0] edge_cnt_q;
   logic [15:0] exp_bits_q;
   logic [15:0] hi_run_q;

   // edge count per write, strobe run length
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q     <= 1'b1;
         sclk_prev_q <= 1'b0;
         edge_cnt_q  <= '0;
         exp_bits_q  <= '0;
         hi_run_q    <= '0;
      end else begin
         sclk_prev_q <= ser_clk;
         if (req_valid && !busy) begin
            first_q    <= 1'b0;
            edge_cnt_q <= '0;
            exp_bits_q <= first_q ? 16'(LEAD_FIRST + 7) : 16'(LEAD_NEXT + 7);
         end else if (ser_clk && !sclk_prev_q) begin
            edge_cnt_q <= edge_cnt_q + 16'd1;
         end
         if (ser_data && !ser_clk) begin
            hi_run_q <= hi_run_q + 16'd1;
         end else begin
            hi_run_q <= '0;
         end
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_clk && !ser_data));

   assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> (busy && !ser_clk && !ser_data));

   assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> $stable(ser_data));

   assert_edge_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (edge_cnt_q == exp_bits_q));

   assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ser_data) && !$past(ser_clk)) |-> (hi_run_q == 16'(STROBE_CYC)));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_busy_ends_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

bind lcd2w_writer lcd2w_writer_chk #(
   .STROBE_CYC (STROBE_CYC),
   .LEAD_FIRST (LEAD_FIRST),
   .LEAD_NEXT  (LEAD_NEXT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .ser_data  (ser_data),
   .ser_clk   (ser_clk)
);

// File: tb/lcd2w_writer_bench.sv
`timescale 1ns/1ps
module lcd2w_writer_bench;

   localparam int HI  = 4;
   localparam int LO  = 4;
   localparam int STB = 46;
   localparam int SET = 10;
   localparam int LF  = 7;
   localparam int LN  = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_rs = 1'b0;
   logic [3:0] req_nibble = 4'h0;
   logic       busy, done, ser_data, ser_clk;

   int checks = 0;
   int errors = 0;

   lcd2w_writer #(
      .CLK_HI_CYC (HI),
      .CLK_LO_CYC (LO),
      .STROBE_CYC (STB),
      .SETTLE_CYC (SET),
      .LEAD_FIRST (LF),
      .LEAD_NEXT  (LN)
   ) u_lcd2w_writer (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_rs     (req_rs),
      .req_nibble (req_nibble),
      .busy       (busy),
      .done       (done),
      .ser_data   (ser_data),
      .ser_clk    (ser_clk)
   );

   always #5 clk = ~clk;

   // ---------------- monitor: external register model and timing ----------
   logic [7:0] ext_sr = 8'hFF;
   logic       prev_clk = 1'b0, prev_data = 1'b0, prev_en = 1'b0, en;
   bit         cap_bits [0:31];
   int         cap_n, hi_run, lo_run, hi_bad, lo_bad, hold_bad;
   int         en_rises, en_cur, en_width, gap_cnt, gap_val, done_cnt;
   bit         strobe_seen;
   logic [7:0] sr_at_en;

   always @(posedge clk) begin
      #1;
      if (ser_clk && !prev_clk) begin
         ext_sr = {ext_sr[6:0], ser_data};
         if (cap_n < 32) cap_bits[cap_n] = ser_data;
         cap_n++;
      end
      if (ser_clk) begin
         if (!prev_clk) begin
            if (lo_run != LO) lo_bad++;
            lo_run = 0;
         end
         hi_run++;
         if (ser_data != prev_data) hold_bad++;
      end else begin
         if (prev_clk) begin
            if (hi_run != HI) hi_bad++;
            hi_run = 0;
         end
         if (busy) lo_run++;
         else lo_run = 0;
      end
      en = ext_sr[6] & ser_data;
      if (en && !prev_en) begin
         en_rises++;
         en_cur = 0;
         sr_at_en = ext_sr;
      end
      if (en) en_cur++;
      if (!en && prev_en) en_width = en_cur;
      if (prev_data && !ser_data && !prev_clk && !ser_clk) begin
         strobe_seen = 1;
         gap_cnt = 0;
      end
      if (strobe_seen && !done) gap_cnt++;
      if (done) begin
         done_cnt++;
         if (strobe_seen) begin
            gap_val = gap_cnt;
            strobe_seen = 0;
         end
      end
      prev_clk  = ser_clk;
      prev_data = ser_data;
      prev_en   = en;
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #3;
      end
   endtask

   task automatic clear_mon();
      cap_n = 0; hi_run = 0; lo_run = 0; hi_bad = 0; lo_bad = 0; hold_bad = 0;
      en_rises = 0; en_cur = 0; en_width = -1; gap_cnt = 0; gap_val = -1;
      done_cnt = 0; strobe_seen = 0; sr_at_en = 8'h00;
   endtask

   function automatic bit exp_bit(input int i, input int lead, input bit rs, input logic [3:0] nib);
      int k;
      if (i < lead) return 1'b0;
      k = i - lead;
      case (k)
         0: return 1'b1;
         1: return rs;
         2: return nib[3];
         3: return nib[2];
         4: return nib[1];
         5: return nib[0];
         default: return 1'b0;
      endcase
   endfunction

   // issue a request from the current point; R4 acceptance checked
   task automatic issue(input bit rs, input logic [3:0] nib);
      clear_mon();
      req_valid  = 1'b1;
      req_rs     = rs;
      req_nibble = nib;
      step(1);
      req_valid = 1'b0;
      chk(busy && !ser_clk && !ser_data, "R4 accept state",
          int'({busy, ser_clk, ser_data}), 4);
   endtask

   task automatic wait_done();
      for (int i = 0; i < 4000; i++) begin
         if (done) begin
            chk(!busy, "R8 busy low with done", int'(busy), 0);
            return;
         end
         step(1);
      end
      chk(1'b0, "R8 done timeout", 0, 1);
   endtask

   task automatic check_frame(input bit rs, input logic [3:0] nib, input int lead);
      int mism = 0;
      chk(cap_n == lead + 7, "R3 rising edge count", cap_n, lead + 7);
      for (int i = 0; i < 32; i++) begin
         if (i < cap_n && cap_bits[i] != exp_bit(i, lead, rs, nib)) mism++;
      end
      chk(mism == 0, "R2 stream order mismatches", mism, 0);
      chk(hi_bad == 0 && lo_bad == 0, "R4 clock phase widths", hi_bad + lo_bad, 0);
      chk(hold_bad == 0, "R5 data change while clock high", hold_bad, 0);
      chk(en_rises == 1, "R7 enable pulses per write", en_rises, 1);
      chk(sr_at_en[6:1] == {1'b1, rs, nib}, "R7 register fields at enable",
          int'(sr_at_en[6:1]), int'({1'b1, rs, nib}));
      chk(en_width == STB, "R6 strobe width", en_width, STB);
      chk(gap_val == SET, "R8 settle cycles before done", gap_val, SET);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      step(3);
      chk(!busy && !done && !ser_clk && !ser_data, "R1 outputs in reset",
          int'({busy, done, ser_clk, ser_data}), 0);
      rst_n = 1'b1;
      step(5);
      chk(!busy && !done && !ser_clk && !ser_data, "R1 idle after reset",
          int'({busy, done, ser_clk, ser_data}), 0);
   endtask

   task automatic t_write(input bit rs, input logic [3:0] nib, input int lead);
      issue(rs, nib);
      wait_done();
      step(1);
      check_frame(rs, nib, lead);
   endtask

   task automatic t_ignore();
      issue(1'b0, 4'h3);
      step(20);
      req_valid = 1'b1; req_rs = 1'b1; req_nibble = 4'hC;
      step(1);
      req_valid = 1'b0;
      wait_done();
      step(1);
      check_frame(1'b0, 4'h3, LN);
      chk(done_cnt == 1, "R9 single done", done_cnt, 1);
      clear_mon();
      step(80);
      chk(cap_n == 0 && done_cnt == 0 && !busy, "R9 dropped request not replayed",
          cap_n + done_cnt, 0);
   endtask

   task automatic t_back_to_back();
      issue(1'b1, 4'h6);
      wait_done();
      check_frame(1'b1, 4'h6, LN);
      clear_mon();
      req_valid = 1'b1; req_rs = 1'b0; req_nibble = 4'h9;
      step(1);
      req_valid = 1'b0;
      chk(busy, "R10 accept in done cycle", int'(busy), 1);
      wait_done();
      step(1);
      check_frame(1'b0, 4'h9, LN);
   endtask

   task automatic t_reset_mid();
      issue(1'b0, 4'hC);
      step(30);
      rst_n = 1'b0;
      step(1);
      chk(!busy && !done && !ser_clk && !ser_data, "R1 reset during write",
          int'({busy, done, ser_clk, ser_data}), 0);
      rst_n = 1'b1;
      step(4);
      t_write(1'b1, 4'h3, LF);  // R3: first write after reset uses the long run
   endtask

   initial begin
      clear_mon();
      t_reset();
      t_write(1'b1, 4'hA, LF);  // R2 R3 first write
      t_write(1'b0, 4'h5, LN);  // R3 later writes
      t_write(1'b1, 4'hF, LN);
      t_write(1'b0, 4'h0, LN);
      t_write(1'b1, 4'h9, LN);
      t_ignore();
      t_back_to_back();
      t_reset_mid();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule